// File: doc/BRIEF.md
# I2C Multi-Master Arbitration Monitor

This block sits beside a bit-level I2C master engine and watches the shared open-drain clock and data lines. It decides when the local master has lost arbitration. Each bus line passes through its own synchronizer. On every rising clock edge the block samples the data line and compares it with the level the engine meant to put out. Start and stop conditions are detected on the bus and keep a bus-busy flag up to date. Requests from the engine that the bus state does not allow, such as a start on a busy bus or a repeated start without ownership, are treated as losses too.

When a loss is seen, the block drops the controller out of master mode and into slave receive mode within one clock. It withdraws its permission for the engine to pull the data line low. It does not create a stop condition. A one-cycle loss pulse marks each event. A sticky status bit records it until software writes a 1 to clear it, and an interrupt output follows that bit when interrupts are enabled. The switch to slave receive happens whether or not interrupts are enabled, so polled and interrupt-driven software see the same mode change.

The mode machine has three states. MODE_IDLE means not master and no loss pending. MODE_MASTER means the local engine owns the bus. MODE_SLAVE_RX means the controller listens after a loss. The transitions are:
- grant: MODE_IDLE or MODE_SLAVE_RX to MODE_MASTER, on a start request while the bus is free.
- forfeit: any state to MODE_SLAVE_RX, on any loss.
- release: MODE_MASTER to MODE_IDLE, on a stop that the engine requested.
- settle: MODE_SLAVE_RX to MODE_IDLE, once the bus is free.

Top module: `i2c_arb_guard`

## Requirements
- R1: `bus_busy` is 0 after reset. It rises when SDA falls while SCL is high (start) and falls when SDA rises while SCL is high (stop). SDA changes while SCL is low leave it unchanged.
- R2: A `req_start` pulse while not master and with the bus free makes `is_master` 1 on the next cycle, with no loss.
- R3: With `bit_kind` = 1 (transmit bit), a rising SCL edge that samples SDA low while `sda_level` is 1 is a loss.
- R4: With `bit_kind` = 2 (acknowledge bit of a receive byte), the same mismatch is a loss. `bit_kind` values 0 and 3 are never compared, and a bit with `sda_level` = 0 never causes a loss.
- R5: A `req_start` pulse while `bus_busy` is 1 is a loss, in any mode.
- R6: A `req_rstart` pulse while not master is a loss. The same pulse while master has no effect.
- R7: A stop detected while master, with no earlier `req_stop` in that ownership, is a loss. After a `req_stop`, the stop returns the block to idle with no loss.
- R8: On a loss, on the next cycle `is_master` is 0, `slave_rx` is 1 and `lost_pulse` is 1 for exactly one cycle. `sda_oe` equals the inverse of `sda_level` while master and is 0 otherwise, so no stop is driven after a loss.
- R9: `slave_rx` stays 1 while the bus is busy. One cycle after `bus_busy` is 0, the block is in idle.
- R10: `arb_lost` is set by any loss. It is cleared only by `clr_wr` with `clr_data` = 1. `clr_data` = 0 has no effect. A loss in the same cycle as a clear leaves the bit set.
- R11: `irq` equals `arb_lost` AND `irq_en`. The mode switch of R8 does not depend on `irq_en`.
- R12: After reset, `is_master`, `slave_rx`, `sda_oe`, `bus_busy`, `arb_lost`, `lost_pulse` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| req_start | input | 1 | Engine requests a start (one-cycle pulse) |
| req_rstart | input | 1 | Engine requests a repeated start (pulse) |
| req_stop | input | 1 | Engine announces it will drive a stop (pulse) |
| bit_kind | input | 2 | Current bit: 0 none, 1 transmit, 2 receive acknowledge, 3 none |
| sda_level | input | 1 | SDA level the engine intends for the current bit |
| clr_wr | input | 1 | Status write strobe |
| clr_data | input | 1 | Status write data; 1 clears the lost bit |
| irq_en | input | 1 | Interrupt enable |
| is_master | output | 1 | Controller is in master mode |
| slave_rx | output | 1 | Controller is in slave receive after a loss |
| sda_oe | output | 1 | Permission to pull SDA low |
| bus_busy | output | 1 | Bus is between a start and a stop |
| arb_lost | output | 1 | Sticky arbitration-lost status |
| lost_pulse | output | 1 | One-cycle marker of each loss event |
| irq | output | 1 | Arbitration-lost interrupt |

## Verification
A wrong mode state shows up at the ports on the very next cycle: `is_master` or `slave_rx` takes the wrong value, and `sda_oe` goes on pulling low or stays silent when it should not. A wrong bus-busy or edge history needs one synchronizer delay plus one clock, about three cycles after the line change, before it shows up as a missed or false loss on a start request, a repeated start or a stop. A corrupted status bit shows at once on `arb_lost` and `irq`. It can only be observed across clear writes, including one written in the same cycle as a loss.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;

    // Classification of the bit the engine is currently handling
    typedef enum logic [1:0] {
        BIT_NONE  = 2'd0,
        BIT_XMIT  = 2'd1,
        BIT_RXACK = 2'd2,
        BIT_SPARE = 2'd3
    } bit_kind_e;

    // Controller ownership mode
    typedef enum logic [1:0] {
        MODE_IDLE     = 2'd0,
        MODE_MASTER   = 2'd1,
        MODE_SLAVE_RX = 2'd2
    } mode_e;

    // Bus events derived from the synchronized lines
    typedef struct packed {
        logic scl_rise;
        logic start_seen;
        logic stop_seen;
        logic sda_now;
    } bus_evt_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int   STAGES   = 2,
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_raw,
    output logic line_now,
    output logic line_prev
);
    localparam int DEPTH = STAGES + 1;

    // Synchronizer stages followed by one history stage for edge detection
    logic [DEPTH-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {DEPTH{IDLE_LVL}};
        end else begin
            chain <= {chain[DEPTH-2:0], line_raw};
        end
    end

    always_comb begin
        line_now  = chain[STAGES-1];
        line_prev = chain[STAGES];
    end
endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch
    import i2c_arb_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_raw,
    input  logic     sda_raw,
    output bus_evt_t evt,
    output logic     bus_busy
);
    localparam int NLINES = 2;
    localparam int IX_SDA = 0;
    localparam int IX_SCL = 1;

    logic [NLINES-1:0] raw_l;
    logic [NLINES-1:0] now_l;
    logic [NLINES-1:0] prev_l;
    logic              scl_held;

    assign raw_l = {scl_raw, sda_raw};

    for (genvar g = 0; g < NLINES; g++) begin : g_sync
        i2c_line_sync #(
            .STAGES  (STAGES),
            .IDLE_LVL(1'b1)
        ) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .line_raw (raw_l[g]),
            .line_now (now_l[g]),
            .line_prev(prev_l[g])
        );
    end

    always_comb begin
        scl_held       = now_l[IX_SCL] & prev_l[IX_SCL];
        evt.scl_rise   = now_l[IX_SCL] & ~prev_l[IX_SCL];
        evt.start_seen = scl_held & prev_l[IX_SDA] & ~now_l[IX_SDA];
        evt.stop_seen  = scl_held & ~prev_l[IX_SDA] & now_l[IX_SDA];
        evt.sda_now    = now_l[IX_SDA];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_busy <= 1'b0;
        end else if (evt.start_seen) begin
            bus_busy <= 1'b1;
        end else if (evt.stop_seen) begin
            bus_busy <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_arb_fsm.sv
module i2c_arb_fsm
    import i2c_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  bus_evt_t   evt,
    input  logic       bus_busy,
    input  logic       req_start,
    input  logic       req_rstart,
    input  logic       req_stop,
    input  logic [1:0] bit_kind,
    input  logic       sda_level,
    output logic       loss_evt,
    output logic       is_master,
    output logic       slave_rx,
    output logic       sda_oe
);
    mode_e     cur_mode;
    mode_e     nxt_mode;
    bit_kind_e kind;
    logic      stop_pend;
    logic      bit_clash;
    logic      rogue_stop;
    logic      busy_start;

    assign kind = bit_kind_e'(bit_kind);

    // Mode register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_mode <= MODE_IDLE;
        end else begin
            cur_mode <= nxt_mode;
        end
    end

    // A stop announced by the engine during the current ownership
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stop_pend <= 1'b0;
        end else if (nxt_mode != MODE_MASTER) begin
            stop_pend <= 1'b0;
        end else if (cur_mode == MODE_MASTER && req_stop) begin
            stop_pend <= 1'b1;
        end
    end

    // Loss conditions and next mode
    always_comb begin
        bit_clash  = evt.scl_rise && sda_level && !evt.sda_now &&
                     (kind == BIT_XMIT || kind == BIT_RXACK);
        rogue_stop = evt.stop_seen && !stop_pend;
        busy_start = req_start && bus_busy;
        nxt_mode   = cur_mode;
        loss_evt   = 1'b0;
        unique case (cur_mode)
            MODE_IDLE, MODE_SLAVE_RX: begin
                if (req_rstart || busy_start) begin
                    loss_evt = 1'b1;
                    nxt_mode = MODE_SLAVE_RX;
                end else if (req_start) begin
                    nxt_mode = MODE_MASTER;
                end else if (cur_mode == MODE_SLAVE_RX && !bus_busy) begin
                    nxt_mode = MODE_IDLE;
                end
            end
            MODE_MASTER: begin
                if (bit_clash || rogue_stop || busy_start) begin
                    loss_evt = 1'b1;
                    nxt_mode = MODE_SLAVE_RX;
                end else if (evt.stop_seen) begin
                    nxt_mode = MODE_IDLE;
                end
            end
            default: begin
                nxt_mode = MODE_IDLE;
            end
        endcase
    end

    // Mode outputs
    always_comb begin
        is_master = (cur_mode == MODE_MASTER);
        slave_rx  = (cur_mode == MODE_SLAVE_RX);
        sda_oe    = is_master && !sda_level;
    end
endmodule

// File: rtl/i2c_arb_status.sv
module i2c_arb_status (
    input  logic clk,
    input  logic rst_n,
    input  logic loss_evt,
    input  logic clr_wr,
    input  logic clr_data,
    input  logic irq_en,
    output logic arb_lost,
    output logic lost_pulse,
    output logic irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arb_lost   <= 1'b0;
            lost_pulse <= 1'b0;
        end else begin
            lost_pulse <= loss_evt;
            if (loss_evt) begin
                arb_lost <= 1'b1;
            end else if (clr_wr && clr_data) begin
                arb_lost <= 1'b0;
            end
        end
    end

    assign irq = arb_lost && irq_en;
endmodule

// File: rtl/i2c_arb_guard.sv
module i2c_arb_guard
    import i2c_arb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic       req_start,
    input  logic       req_rstart,
    input  logic       req_stop,
    input  logic [1:0] bit_kind,
    input  logic       sda_level,
    input  logic       clr_wr,
    input  logic       clr_data,
    input  logic       irq_en,
    output logic       is_master,
    output logic       slave_rx,
    output logic       sda_oe,
    output logic       bus_busy,
    output logic       arb_lost,
    output logic       lost_pulse,
    output logic       irq
);
    bus_evt_t evt;
    logic     loss_evt;

    i2c_bus_watch #(
        .STAGES(SYNC_STAGES)
    ) u_watch (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_raw (scl_in),
        .sda_raw (sda_in),
        .evt     (evt),
        .bus_busy(bus_busy)
    );

    i2c_arb_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .bus_busy  (bus_busy),
        .req_start (req_start),
        .req_rstart(req_rstart),
        .req_stop  (req_stop),
        .bit_kind  (bit_kind),
        .sda_level (sda_level),
        .loss_evt  (loss_evt),
        .is_master (is_master),
        .slave_rx  (slave_rx),
        .sda_oe    (sda_oe)
    );

    i2c_arb_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .loss_evt  (loss_evt),
        .clr_wr    (clr_wr),
        .clr_data  (clr_data),
        .irq_en    (irq_en),
        .arb_lost  (arb_lost),
        .lost_pulse(lost_pulse),
        .irq       (irq)
    );
endmodule

// File: rtl/i2c_arb_guard_chk.sv
module i2c_arb_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_in,
    input logic       sda_in,
    input logic       req_start,
    input logic       req_rstart,
    input logic       req_stop,
    input logic [1:0] bit_kind,
    input logic       sda_level,
    input logic       clr_wr,
    input logic       clr_data,
    input logic       irq_en,
    input logic       is_master,
    input logic       slave_rx,
    input logic       sda_oe,
    input logic       bus_busy,
    input logic       arb_lost,
    input logic       lost_pulse,
    input logic       irq
);
    // R2
    start_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_master && req_start && !req_rstart && !bus_busy) |=> is_master);

    // R8
    pulse_demotes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lost_pulse |-> (!is_master && slave_rx && !sda_oe));

    // R10
    pulse_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lost_pulse |-> arb_lost);

    // R10
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost && !(clr_wr && clr_data)) |=> arb_lost);

    // R11
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);
endmodule

bind i2c_arb_guard i2c_arb_guard_chk chk_i (.*);

// File: tb/i2c_arb_guard_tb_top.sv
`timescale 1ns/1ps
module i2c_arb_guard_tb_top;
    localparam int SYNC   = 2;
    localparam int SETTLE = SYNC + 1;
    localparam int WD_CYC = 150000;
    localparam logic [1:0] K_NONE = 2'd0;
    localparam logic [1:0] K_TX   = 2'd1;
    localparam logic [1:0] K_ACK  = 2'd2;
    localparam logic [1:0] K_SPR  = 2'd3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_in = 1'b1;
    logic       sda_in = 1'b1;
    logic       req_start = 1'b0;
    logic       req_rstart = 1'b0;
    logic       req_stop = 1'b0;
    logic [1:0] bit_kind = 2'd0;
    logic       sda_level = 1'b1;
    logic       clr_wr = 1'b0;
    logic       clr_data = 1'b0;
    logic       irq_en = 1'b0;
    logic       is_master, slave_rx, sda_oe, bus_busy, arb_lost, lost_pulse, irq;

    int total = 0;
    int bad = 0;
    int pulses = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    i2c_arb_guard #(.SYNC_STAGES(SYNC)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .req_start(req_start), .req_rstart(req_rstart), .req_stop(req_stop),
        .bit_kind(bit_kind), .sda_level(sda_level), .clr_wr(clr_wr),
        .clr_data(clr_data), .irq_en(irq_en), .is_master(is_master),
        .slave_rx(slave_rx), .sda_oe(sda_oe), .bus_busy(bus_busy),
        .arb_lost(arb_lost), .lost_pulse(lost_pulse), .irq(irq)
    );

    // Count loss pulses well away from the clock edges
    always @(posedge clk) begin
        #1;
        if (rst_n && lost_pulse) pulses++;
    end

    function automatic logic clash(input logic [1:0] k, input logic lv, input logic ln);
        return (k == K_TX || k == K_ACK) && lv && !ln;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic lines(input logic c, input logic d);
        scl_in = c;
        sda_in = d;
        wait_n(SETTLE);
    endtask

    task automatic do_start();
        req_start = 1'b1; wait_n(1); req_start = 1'b0;
    endtask

    task automatic do_rstart();
        req_rstart = 1'b1; wait_n(1); req_rstart = 1'b0;
    endtask

    task automatic do_stopreq();
        req_stop = 1'b1; wait_n(1); req_stop = 1'b0;
    endtask

    task automatic wr_status(input logic d);
        clr_wr = 1'b1; clr_data = d; wait_n(1); clr_wr = 1'b0; clr_data = 1'b0;
    endtask

    task automatic bus_start();
        bit_kind = K_NONE;
        lines(1'b1, 1'b1);
        lines(1'b1, 1'b0);
        lines(1'b0, 1'b0);
    endtask

    task automatic bus_stop();
        bit_kind = K_NONE;
        lines(1'b0, 1'b0);
        lines(1'b1, 1'b0);
        lines(1'b1, 1'b1);
    endtask

    task automatic send_bit(input logic [1:0] k, input logic lv, input logic ln);
        scl_in = 1'b0;
        wait_n(SETTLE);
        bit_kind = k; sda_level = lv; sda_in = ln;
        wait_n(SETTLE);
        scl_in = 1'b1;
        wait_n(SETTLE);
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int p0;
        int seed;
        seed = $urandom(32'h5EED_0042);
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);

        // R12 reset state
        chk("R12 is_master", is_master, 0);
        chk("R12 slave_rx", slave_rx, 0);
        chk("R12 sda_oe", sda_oe, 0);
        chk("R12 bus_busy", bus_busy, 0);
        chk("R12 arb_lost", arb_lost, 0);
        chk("R12 lost_pulse", lost_pulse, 0);
        chk("R12 irq", irq, 0);

        // R1 data moves with SCL low do not mark the bus busy
        lines(1'b0, 1'b1); lines(1'b0, 1'b0); lines(1'b0, 1'b1);
        chk("R1 low-scl toggles", bus_busy, 0);
        lines(1'b1, 1'b1);
        lines(1'b1, 1'b0);
        chk("R1 start sets busy", bus_busy, 1);
        lines(1'b0, 1'b0);

        // R5 start request on a busy bus (another master owns it)
        p0 = pulses;
        do_start();
        chk("R5 loss on busy start", arb_lost, 1);
        chk("R5 not master", is_master, 0);
        chk("R8 slave_rx after loss", slave_rx, 1);
        chk("R8 pulse count", pulses - p0, 1);
        bus_stop();
        chk("R1 stop clears busy", bus_busy, 0);
        chk("R9 slave_rx until settle", slave_rx, 1);
        wait_n(1);
        chk("R9 idle after free bus", slave_rx, 0);

        // R10 and R11 status and interrupt
        wr_status(1'b0);
        chk("R10 write 0 ignored", arb_lost, 1);
        chk("R11 irq masked", irq, 0);
        irq_en = 1'b1;
        wait_n(1);
        chk("R11 irq enabled", irq, 1);
        wr_status(1'b1);
        chk("R10 write 1 clears", arb_lost, 0);
        chk("R11 irq follows clear", irq, 0);

        // R6 repeated start while not master
        do_rstart();
        chk("R6 rstart idle loss", arb_lost, 1);
        chk("R6 rstart slave_rx", slave_rx, 1);
        wait_n(1);
        chk("R9 back to idle", slave_rx, 0);
        wr_status(1'b1);

        // R10 loss in the same cycle as a clear wins
        clr_wr = 1'b1; clr_data = 1'b1; req_rstart = 1'b1;
        wait_n(1);
        clr_wr = 1'b0; clr_data = 1'b0; req_rstart = 1'b0;
        chk("R10 loss beats clear", arb_lost, 1);
        wait_n(1);
        wr_status(1'b1);
        chk("R10 cleared", arb_lost, 0);

        // R2, R6, R5 while master
        do_start();
        chk("R2 grant", is_master, 1);
        chk("R2 no loss", arb_lost, 0);
        bus_start();
        do_rstart();
        chk("R6 rstart as master ok", is_master, 1);
        chk("R6 rstart as master no loss", arb_lost, 0);
        send_bit(K_TX, 1'b0, 1'b0);
        chk("R8 sda_oe drives low", sda_oe, 1);
        send_bit(K_NONE, 1'b1, 1'b0);
        chk("R4 kind none ignored", arb_lost, 0);
        send_bit(K_SPR, 1'b1, 1'b0);
        chk("R4 kind 3 ignored", arb_lost, 0);
        chk("R4 still master", is_master, 1);
        do_start();
        chk("R5 start while master busy", arb_lost, 1);
        chk("R5 demoted", is_master, 0);
        bus_stop();
        wait_n(1);
        wr_status(1'b1);

        // R7 unrequested stop with interrupts off, R11 mode switch anyway
        irq_en = 1'b0;
        do_start();
        bus_start();
        send_bit(K_TX, 1'b1, 1'b1);
        chk("R3 match no loss", arb_lost, 0);
        p0 = pulses;
        bus_stop();
        chk("R7 rogue stop loss", arb_lost, 1);
        chk("R11 switch without irq", is_master, 0);
        chk("R11 irq off", irq, 0);
        chk("R8 one pulse", pulses - p0, 1);
        wait_n(1);
        wr_status(1'b1);

        // R7 requested stop
        do_start();
        bus_start();
        do_stopreq();
        bus_stop();
        chk("R7 requested stop no loss", arb_lost, 0);
        chk("R7 released", is_master, 0);
        chk("R7 not slave", slave_rx, 0);

        // Random transfers
        for (int it = 0; it < 30; it++) begin
            int nb;
            logic exp_lost;
            wr_status(1'b1);
            p0 = pulses;
            exp_lost = 1'b0;
            do_start();
            chk("R2 random grant", is_master, 1);
            bus_start();
            chk("R1 random busy", bus_busy, 1);
            nb = 2 + int'($urandom % 10);
            for (int b = 0; b < nb; b++) begin
                logic [1:0] k;
                logic lv, ln;
                k  = 2'($urandom % 4);
                lv = 1'($urandom % 2);
                ln = lv ? (($urandom % 4) != 0) : 1'b0;
                if (!exp_lost && clash(k, lv, ln)) exp_lost = 1'b1;
                send_bit(k, lv, ln);
                chk((k == K_ACK) ? "R4 random ack bit" : "R3 random bit", arb_lost, int'(exp_lost));
                chk("R8 random master", is_master, int'(!exp_lost));
                chk("R8 random slave_rx", slave_rx, int'(exp_lost));
                chk("R8 random sda_oe", sda_oe, int'(!exp_lost && !lv));
            end
            if (!exp_lost) do_stopreq();
            bus_stop();
            chk("R7 random end lost", arb_lost, int'(exp_lost));
            chk("R8 random pulses", pulses - p0, int'(exp_lost));
            chk("R1 random free", bus_busy, 0);
            wait_n(1);
            chk("R9 random idle", slave_rx, 0);
            chk("R9 random not master", is_master, 0);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule